// File: doc/BRIEF.md
# Charge Sequencing Controller

This block sequences a single-cell lithium charger through its phases: a settling wait after the supply is attached, a low-current conditioning phase for a deeply discharged cell, constant-current charging, constant-voltage charging, completion, a suspended state and a latched fault. The analog comparators, the current loop and the current programming sit outside the block. The controller receives their decisions as synchronous flags, together with an enable request and a 1 ms tick. It returns a one-hot enable for the active regulation loop and an active-low indicator that drives a status LED.

Every time window is a parameter expressed in ticks. All windows are divided by a common scaling parameter, so a short simulation can run the same sequence with the same structure. Each phase exit has its own persistence window. The conditioning phase and the combined constant-current and constant-voltage phases each have a long safety limit. The enable and temperature inputs pass through persistence filters before the phase logic sees them.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset `phase` is 0 (idle wait), `loop_en` is 000 and `stat_n` is 1.
- R2: With `in_ok` high, the controller leaves the wait phase on the CONN-th tick, counted from when `in_ok` went high. It enters conditioning (phase 1) if the filtered enable is high and the filtered temperature is good. Otherwise it enters the suspended phase (phase 5).
- R3: Conditioning moves to constant current (phase 2) on the PRE_OK-th consecutive tick with `bat_low` low. Any cycle with `bat_low` high restarts this count.
- R4: In constant current, `bat_low` held high for FALL consecutive ticks leads to fault (phase 6), and a shorter burst has no effect. `v_float` high moves the controller to constant voltage (phase 3) in the next cycle.
- R5: In constant voltage, `i_low` held for EOC consecutive ticks leads to done (phase 4), with `loop_en` at 000 and `stat_n` at 1.
- R6: Conditioning that lasts PRE_MAX ticks leads to fault. Constant current and constant voltage together lasting FAST_MAX ticks, counted from entry into constant current, also lead to fault.
- R7: `ntc_hot` or `ntc_cold` must persist for NTC ticks before charging is suspended. Once both are clear for NTC ticks, charging resumes in conditioning. Shorter excursions are ignored.
- R8: `stat_n` is 0 in phases 1 to 3 and 1 in phases 0, 4 and 5. In fault it starts at 0 and inverts every BLINK ticks.
- R9: When `in_ok` is low, the next cycle is in the wait phase and all phase timers restart.
- R10: `chg_en` passes through a filter that needs EN ticks of a new level. A low filtered enable moves any charging phase, or done, to suspended. Shorter enable pulses are ignored.
- R11: Fault is left only to the wait phase, either by `in_ok` going low or by the filtered enable going low.
- R12: Phase codes are 0 wait, 1 conditioning, 2 constant current, 3 constant voltage, 4 done, 5 suspended and 6 fault. `loop_en` has bit 0 set for conditioning, bit 1 for constant current and bit 2 for constant voltage, with at most one bit set.
- R13: Each window is its parameter value divided by `TICK_DIV`, rounded down, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time base pulse (nominally 1 ms) |
| in_ok | input | 1 | Supply within its valid window |
| bat_low | input | 1 | Cell below the conditioning threshold |
| i_low | input | 1 | Charge current below the completion threshold |
| v_float | input | 1 | Cell has reached the float voltage |
| ntc_hot | input | 1 | Thermistor reports too hot |
| ntc_cold | input | 1 | Thermistor reports too cold |
| chg_en | input | 1 | Charge enable request |
| phase | output | 3 | Current phase code |
| loop_en | output | 3 | One-hot enable for the active regulation loop |
| stat_n | output | 1 | Active-low status indicator |

## Verification
The assertions check several properties on every cycle: that `loop_en` is one-hot, that `stat_n` tracks the charging phases, that a supply drop returns the controller to the wait phase at once, and that a filtered over-temperature or disable stops the loops. They also check that fault holds while the supply and enable stay good, and that the conditioning exit and timeout events steer the phase. The exact tick on which each window ends, the rejection of bursts one tick short, the blink cadence and the rounding of scaled windows can only be seen in the bench scenarios. The bench computes these from the raw parameters and the divisor.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_PRE   = 3'd1,
    PH_FAST  = 3'd2,
    PH_CV    = 3'd3,
    PH_DONE  = 3'd4,
    PH_SUSP  = 3'd5,
    PH_FAULT = 3'd6
  } phase_e;

  // Window length after scaling: floor(raw/div), never below one tick.
  function automatic int unsigned scale_ticks(input int unsigned raw,
                                              input int unsigned div);
    int unsigned q;
    q = (div == 0) ? raw : raw / div;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Regulation loop selected by a phase: bit0 low-current, bit1 CC, bit2 CV.
  function automatic logic [2:0] loop_of(input phase_e ph);
    case (ph)
      PH_PRE:  return 3'b001;
      PH_FAST: return 3'b010;
      PH_CV:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/chg_level_filter.sv
module chg_level_filter #(
  parameter int unsigned HOLD_T = 3,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(HOLD_T + 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= INIT;
    end else if (raw == filt_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= CW'(HOLD_T - 1)) begin
        filt_q <= raw;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
  import chg_seq_pkg::*;
#(
  parameter int unsigned CONN_T     = 240,
  parameter int unsigned PRE_OK_T   = 100,
  parameter int unsigned FALL_T     = 10,
  parameter int unsigned EOC_T      = 100,
  parameter int unsigned PRE_MAX_T  = 1800000,
  parameter int unsigned FAST_MAX_T = 36000000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   in_ok,
  input  logic   bat_low,
  input  logic   i_low,
  input  logic   v_float,
  input  logic   en_ok,
  input  logic   temp_bad,
  output phase_e phase_q,
  output logic   age_hit,
  output logic   qual_hit
);
  localparam int unsigned AGE_MAX  = max3(CONN_T, PRE_MAX_T, FAST_MAX_T);
  localparam int          AGE_W    = $clog2(AGE_MAX + 1);
  localparam int unsigned QUAL_MAX = max3(PRE_OK_T, FALL_T, EOC_T);
  localparam int          QUAL_W   = $clog2(QUAL_MAX + 1);

  phase_e            phase_d;
  logic [AGE_W-1:0]  age_q, age_lim;
  logic [QUAL_W-1:0] qual_q, qual_lim;
  logic              age_on, qual_cond, keep_age, run_ok;

  // Per-phase window selection: phase age limit and exit qualifier.
  always_comb begin
    age_on    = 1'b0;
    age_lim   = '0;
    qual_cond = 1'b0;
    qual_lim  = '0;
    unique case (phase_q)
      PH_WAIT: begin
        age_on  = 1'b1;
        age_lim = AGE_W'(CONN_T);
      end
      PH_PRE: begin
        age_on    = 1'b1;
        age_lim   = AGE_W'(PRE_MAX_T);
        qual_cond = !bat_low;
        qual_lim  = QUAL_W'(PRE_OK_T);
      end
      PH_FAST: begin
        age_on    = 1'b1;
        age_lim   = AGE_W'(FAST_MAX_T);
        qual_cond = bat_low;
        qual_lim  = QUAL_W'(FALL_T);
      end
      PH_CV: begin
        age_on    = 1'b1;
        age_lim   = AGE_W'(FAST_MAX_T);
        qual_cond = i_low;
        qual_lim  = QUAL_W'(EOC_T);
      end
      default: ;
    endcase
  end

  assign age_hit  = age_on && tick && (age_q >= age_lim - 1'b1);
  assign qual_hit = qual_cond && tick && (qual_q >= qual_lim - 1'b1);
  assign run_ok   = en_ok && !temp_bad;

  always_comb begin
    phase_d = phase_q;
    if (!in_ok) begin
      phase_d = PH_WAIT;
    end else begin
      unique case (phase_q)
        PH_WAIT:  if (age_hit) phase_d = run_ok ? PH_PRE : PH_SUSP;
        PH_PRE: begin
          if (!run_ok)       phase_d = PH_SUSP;
          else if (age_hit)  phase_d = PH_FAULT;
          else if (qual_hit) phase_d = PH_FAST;
        end
        PH_FAST: begin
          if (!run_ok)       phase_d = PH_SUSP;
          else if (age_hit)  phase_d = PH_FAULT;
          else if (qual_hit) phase_d = PH_FAULT;
          else if (v_float)  phase_d = PH_CV;
        end
        PH_CV: begin
          if (!run_ok)       phase_d = PH_SUSP;
          else if (age_hit)  phase_d = PH_FAULT;
          else if (qual_hit) phase_d = PH_DONE;
        end
        PH_SUSP:  if (run_ok) phase_d = PH_PRE;
        PH_DONE:  if (!en_ok) phase_d = PH_SUSP;
        PH_FAULT: if (!en_ok) phase_d = PH_WAIT;
        default:  phase_d = PH_WAIT;
      endcase
    end
  end

  // The safety limit for CC spans the CV phase as well.
  assign keep_age = (phase_q == PH_FAST) && (phase_d == PH_CV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      age_q   <= '0;
      qual_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (!in_ok || ((phase_d != phase_q) && !keep_age))
        age_q <= '0;
      else if (age_on && tick && (age_q < age_lim))
        age_q <= age_q + 1'b1;
      if ((phase_d != phase_q) || !qual_cond)
        qual_q <= '0;
      else if (tick && (qual_q < qual_lim))
        qual_q <= qual_q + 1'b1;
    end
  end
endmodule

// File: rtl/chg_status_gen.sv
module chg_status_gen
  import chg_seq_pkg::*;
#(
  parameter int unsigned BLINK_T = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  phase_e     phase,
  output logic [2:0] loop_en,
  output logic       stat_n
);
  localparam int BW = $clog2(BLINK_T + 1);

  logic [BW-1:0] blink_cnt_q;
  logic          blink_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_cnt_q <= '0;
      blink_lvl_q <= 1'b0;
    end else if (phase != PH_FAULT) begin
      blink_cnt_q <= '0;
      blink_lvl_q <= 1'b0;
    end else if (tick) begin
      if (blink_cnt_q >= BW'(BLINK_T - 1)) begin
        blink_cnt_q <= '0;
        blink_lvl_q <= !blink_lvl_q;
      end else begin
        blink_cnt_q <= blink_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_PRE, PH_FAST, PH_CV: stat_n = 1'b0;
      PH_FAULT:               stat_n = blink_lvl_q;
      default:                stat_n = 1'b1;
    endcase
  end

  assign loop_en = loop_of(phase);
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
  import chg_seq_pkg::*;
#(
  parameter int unsigned CONN_MS     = 240,
  parameter int unsigned PRE_OK_MS   = 100,
  parameter int unsigned FALL_MS     = 10,
  parameter int unsigned EOC_MS      = 100,
  parameter int unsigned NTC_MS      = 100,
  parameter int unsigned EN_MS       = 30,
  parameter int unsigned PRE_MAX_MS  = 1800000,
  parameter int unsigned FAST_MAX_MS = 36000000,
  parameter int unsigned BLINK_MS    = 500,
  parameter int unsigned TICK_DIV    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_ok,
  input  logic       bat_low,
  input  logic       i_low,
  input  logic       v_float,
  input  logic       ntc_hot,
  input  logic       ntc_cold,
  input  logic       chg_en,
  output logic [2:0] phase,
  output logic [2:0] loop_en,
  output logic       stat_n
);
  localparam int unsigned CONN_T     = scale_ticks(CONN_MS, TICK_DIV);
  localparam int unsigned PRE_OK_T   = scale_ticks(PRE_OK_MS, TICK_DIV);
  localparam int unsigned FALL_T     = scale_ticks(FALL_MS, TICK_DIV);
  localparam int unsigned EOC_T      = scale_ticks(EOC_MS, TICK_DIV);
  localparam int unsigned NTC_T      = scale_ticks(NTC_MS, TICK_DIV);
  localparam int unsigned EN_T       = scale_ticks(EN_MS, TICK_DIV);
  localparam int unsigned PRE_MAX_T  = scale_ticks(PRE_MAX_MS, TICK_DIV);
  localparam int unsigned FAST_MAX_T = scale_ticks(FAST_MAX_MS, TICK_DIV);
  localparam int unsigned BLINK_T    = scale_ticks(BLINK_MS, TICK_DIV);

  // Named internal events, visible to the bound checker.
  logic   en_ok_w, temp_bad_w, age_hit_w, qual_hit_w;
  phase_e phase_w;

  chg_level_filter #(.HOLD_T(EN_T), .INIT(1'b0)) en_filt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(chg_en), .filt(en_ok_w)
  );

  chg_level_filter #(.HOLD_T(NTC_T), .INIT(1'b0)) temp_filt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ntc_hot | ntc_cold),
    .filt(temp_bad_w)
  );

  chg_phase_fsm #(
    .CONN_T(CONN_T), .PRE_OK_T(PRE_OK_T), .FALL_T(FALL_T), .EOC_T(EOC_T),
    .PRE_MAX_T(PRE_MAX_T), .FAST_MAX_T(FAST_MAX_T)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_ok(in_ok),
    .bat_low(bat_low), .i_low(i_low), .v_float(v_float),
    .en_ok(en_ok_w), .temp_bad(temp_bad_w),
    .phase_q(phase_w), .age_hit(age_hit_w), .qual_hit(qual_hit_w)
  );

  chg_status_gen #(.BLINK_T(BLINK_T)) stat_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase_w),
    .loop_en(loop_en), .stat_n(stat_n)
  );

  assign phase = phase_w;
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import chg_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_ok,
  input logic       i_low,
  input logic [2:0] phase,
  input logic [2:0] loop_en,
  input logic       stat_n,
  input logic       en_ok,
  input logic       temp_bad,
  input logic       age_hit,
  input logic       qual_hit
);
  assert_loop_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loop_en));

  assert_stat_low_charging_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en != 3'b000) |-> !stat_n);

  assert_stat_high_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT || phase == PH_SUSP || phase == PH_DONE) |-> stat_n);

  assert_input_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (phase == PH_WAIT));

  assert_done_needs_low_i_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CV && !i_low) |=> (phase != PH_DONE));

  assert_temp_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ok && temp_bad && loop_en != 3'b000) |=> (loop_en == 3'b000));

  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ok && !en_ok && loop_en != 3'b000) |=> (loop_en == 3'b000));

  assert_fault_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAULT && in_ok && en_ok) |=> (phase == PH_FAULT));

  assert_pre_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE && in_ok && en_ok && !temp_bad && qual_hit && !age_hit)
      |=> (phase == PH_FAST));

  assert_pre_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE && in_ok && en_ok && !temp_bad && age_hit)
      |=> (phase == PH_FAULT));
endmodule

bind chg_seq_ctrl chg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ok(in_ok), .i_low(i_low),
  .phase(phase), .loop_en(loop_en), .stat_n(stat_n),
  .en_ok(en_ok_w), .temp_bad(temp_bad_w),
  .age_hit(age_hit_w), .qual_hit(qual_hit_w)
);

// File: tb/chg_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module chg_seq_ctrl_tb_top;
  localparam int DIV       = 2;
  localparam int RAW_CONN  = 16;
  localparam int RAW_PREOK = 10;
  localparam int RAW_FALL  = 7;
  localparam int RAW_EOC   = 8;
  localparam int RAW_NTC   = 8;
  localparam int RAW_EN    = 6;
  localparam int RAW_PMAX  = 80;
  localparam int RAW_FMAX  = 120;
  localparam int RAW_BLINK = 8;

  // R13: effective window = floor(raw / DIV), at least one tick.
  function automatic int eff(input int raw);
    int q;
    q = raw / DIV;
    if (q < 1) q = 1;
    return q;
  endfunction

  localparam int E_CONN  = RAW_CONN / DIV;
  localparam int E_PREOK = RAW_PREOK / DIV;
  localparam int E_FALL  = (RAW_FALL - 1) / DIV;
  localparam int E_EOC   = RAW_EOC / DIV;
  localparam int E_NTC   = RAW_NTC / DIV;
  localparam int E_EN    = RAW_EN / DIV;
  localparam int E_PMAX  = RAW_PMAX / DIV;
  localparam int E_FMAX  = RAW_FMAX / DIV;
  localparam int E_BLINK = RAW_BLINK / DIV;

  logic clk = 1'b0;
  logic rst_n, tick, in_ok, bat_low, i_low, v_float, ntc_hot, ntc_cold, chg_en;
  logic [2:0] phase, loop_en;
  logic stat_n;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  chg_seq_ctrl #(
    .CONN_MS(RAW_CONN), .PRE_OK_MS(RAW_PREOK), .FALL_MS(RAW_FALL),
    .EOC_MS(RAW_EOC), .NTC_MS(RAW_NTC), .EN_MS(RAW_EN),
    .PRE_MAX_MS(RAW_PMAX), .FAST_MAX_MS(RAW_FMAX), .BLINK_MS(RAW_BLINK),
    .TICK_DIV(DIV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_ok(in_ok), .bat_low(bat_low),
    .i_low(i_low), .v_float(v_float), .ntc_hot(ntc_hot), .ntc_cold(ntc_cold),
    .chg_en(chg_en), .phase(phase), .loop_en(loop_en), .stat_n(stat_n)
  );

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic expect_state(input logic [2:0] ph, input logic st, input string tag);
    logic [2:0] exp_en;
    exp_en = (ph == 3'd1) ? 3'b001 : (ph == 3'd2) ? 3'b010 :
             (ph == 3'd3) ? 3'b100 : 3'b000;
    n_tests++;
    if (phase !== ph || loop_en !== exp_en || stat_n !== st) begin
      n_fail++;
      $display("FAIL %s: phase=%0d loop_en=%b stat_n=%b, expected phase=%0d loop_en=%b stat_n=%b",
               tag, phase, loop_en, stat_n, ph, exp_en, st);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; in_ok = 1'b0; bat_low = 1'b0; i_low = 1'b0;
    v_float = 1'b0; ntc_hot = 1'b0; ntc_cold = 1'b0; chg_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_state(3'd0, 1'b1, "R1 reset");

    // R13: odd raw value rounds down
    n_tests++;
    if (eff(RAW_FALL) != E_FALL) begin
      n_fail++;
      $display("FAIL R13: eff=%0d expected %0d", eff(RAW_FALL), E_FALL);
    end

    // R2 connection delay
    in_ok = 1'b1; chg_en = 1'b1; bat_low = 1'b1;
    run_ticks(eff(RAW_CONN) - 1);
    expect_state(3'd0, 1'b1, "R2 before delay");
    run_ticks(1);
    expect_state(3'd1, 1'b0, "R2 R13 enter conditioning");

    // R3 promotion with a one-cycle glitch restarting the count
    bat_low = 1'b0;
    run_ticks(E_PREOK - 1);
    expect_state(3'd1, 1'b0, "R3 not yet");
    bat_low = 1'b1; idle(1); bat_low = 1'b0;
    run_ticks(E_PREOK - 1);
    expect_state(3'd1, 1'b0, "R3 glitch restarted count");
    run_ticks(1);
    expect_state(3'd2, 1'b0, "R3 promoted");

    // R4 short fallback burst ignored, float voltage moves to CV
    bat_low = 1'b1;
    run_ticks(E_FALL - 1);
    bat_low = 1'b0; idle(1);
    expect_state(3'd2, 1'b0, "R4 short burst ignored");
    v_float = 1'b1; idle(1);
    expect_state(3'd3, 1'b0, "R4 to CV");

    // R5 end of charge
    i_low = 1'b1;
    run_ticks(E_EOC - 1);
    expect_state(3'd3, 1'b0, "R5 not yet");
    run_ticks(1);
    expect_state(3'd4, 1'b1, "R5 done");

    // R9 supply drop
    in_ok = 1'b0; idle(1);
    expect_state(3'd0, 1'b1, "R9 back to wait");
    in_ok = 1'b1; i_low = 1'b0; v_float = 1'b0; bat_low = 1'b1;
    run_ticks(E_CONN);
    expect_state(3'd1, 1'b0, "R9 timers restarted");

    // R6 conditioning timeout, R8 blink
    run_ticks(E_PMAX - 1);
    expect_state(3'd1, 1'b0, "R6 pre before limit");
    run_ticks(1);
    expect_state(3'd6, 1'b0, "R6 pre timeout");
    run_ticks(E_BLINK - 1);
    expect_state(3'd6, 1'b0, "R8 blink hold low");
    run_ticks(1);
    expect_state(3'd6, 1'b1, "R8 blink high");
    run_ticks(E_BLINK);
    expect_state(3'd6, 1'b0, "R8 blink low again");

    // R10 short enable pulse ignored, R11 enable toggle clears fault
    chg_en = 1'b0;
    run_ticks(E_EN - 1);
    chg_en = 1'b1; idle(1);
    expect_state(3'd6, 1'b0, "R10 R11 short disable ignored");
    chg_en = 1'b0;
    run_ticks(E_EN); idle(1);
    expect_state(3'd0, 1'b1, "R11 fault cleared by enable");
    chg_en = 1'b1;
    run_ticks(E_CONN - 1);
    expect_state(3'd0, 1'b1, "R2 wait again");
    run_ticks(1);
    expect_state(3'd1, 1'b0, "R2 restart");

    // R4 fallback fault
    bat_low = 1'b0;
    run_ticks(E_PREOK);
    expect_state(3'd2, 1'b0, "R3 promoted again");
    bat_low = 1'b1;
    run_ticks(E_FALL - 1);
    expect_state(3'd2, 1'b0, "R4 fallback pending");
    run_ticks(1);
    expect_state(3'd6, 1'b0, "R4 fallback fault");

    // R11 fault cleared by supply removal
    in_ok = 1'b0; idle(1);
    expect_state(3'd0, 1'b1, "R11 fault cleared by supply");
    in_ok = 1'b1; bat_low = 1'b0;
    run_ticks(E_CONN);
    expect_state(3'd1, 1'b0, "R2 conditioning");
    run_ticks(E_PREOK);
    expect_state(3'd2, 1'b0, "R3 to CC");

    // R7 temperature
    ntc_hot = 1'b1;
    run_ticks(E_NTC - 1);
    ntc_hot = 1'b0; idle(1);
    expect_state(3'd2, 1'b0, "R7 short hot ignored");
    ntc_cold = 1'b1;
    run_ticks(E_NTC); idle(1);
    expect_state(3'd5, 1'b1, "R7 cold suspends");
    ntc_cold = 1'b0;
    run_ticks(E_NTC - 1); idle(1);
    expect_state(3'd5, 1'b1, "R7 resume pending");
    run_ticks(1); idle(1);
    expect_state(3'd1, 1'b0, "R7 resume in conditioning");

    // R6 fast timeout
    run_ticks(E_PREOK);
    expect_state(3'd2, 1'b0, "R3 CC after resume");
    run_ticks(E_FMAX - 1);
    expect_state(3'd2, 1'b0, "R6 CC before limit");
    run_ticks(1);
    expect_state(3'd6, 1'b0, "R6 CC timeout");

    // R10 disable suspends charging, enable resumes
    in_ok = 1'b0; idle(1); in_ok = 1'b1;
    run_ticks(E_CONN);
    expect_state(3'd1, 1'b0, "R2 conditioning again");
    chg_en = 1'b0;
    run_ticks(E_EN); idle(1);
    expect_state(3'd5, 1'b1, "R10 disable suspends");
    chg_en = 1'b1;
    run_ticks(E_EN); idle(1);
    expect_state(3'd1, 1'b0, "R10 enable resumes");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule